// File: doc/BRIEF.md
# Reference Selection and Mode Controller

This block picks which of eight candidate timing references drives a digital phase-locked loop. It also steps the loop through three operating modes: free-run, locked and holdover. External monitors supply one qualification flag per reference. The block combines those flags with a priority value per reference to choose a source automatically, with or without revertive behaviour. Software can instead force the index in manual mode.

The block reports the chosen index and the current mode. It also gives a loop-bandwidth code: a fixed narrow setting, or in wideband mode a setting derived from the measured frequency of the chosen reference. A one-cycle request tells the phase path to absorb the step whenever the chosen index changes and hitless switching is on.

An enable input keeps the controller idle. A secondary loop instance can therefore sit unused until software turns it on. All outputs are registered: inputs seen at one rising edge appear on the outputs after that edge.

Top module: `refsel_ctrl`

## Requirements
- R1: While `rst_n` is low or `enable_i` is low, the next outputs are `mode_o`=0 (free-run), `sel_idx_o`=0, `bw_code_o`=0 and `hitless_req_o`=0, and the record of earlier lock is cleared.
- R2: In automatic mode, when a new reference must be chosen, the block takes the qualified reference (`ref_ok_i` bit = 1) with the numerically lowest priority value (value 0 is the most preferred). On equal values, the lower index wins.
- R3: In automatic mode with `revert_i`=1, if a qualified reference has a strictly lower priority value than the current one, the block selects it after the next edge.
- R4: In automatic mode with `revert_i`=0, the block keeps the current reference for as long as that reference stays qualified.
- R5: In automatic mode, if the current reference loses qualification, the block switches to the best qualified reference. If none is qualified, it keeps the current index.
- R6: The mode is locked (1) when the newly selected reference is qualified and `lock_i`=1. Otherwise it is holdover (2) if the block has been locked since it was last enabled, and free-run (0) if not.
- R7: With `manual_i`=1, the selected index equals `man_idx_i` even when that reference is disqualified. A disqualified manual reference then yields holdover (or free-run without earlier lock), never a switch to another reference.
- R8: `hitless_req_o` is 1 for exactly the cycles in which `sel_idx_o` has just changed while `hitless_en_i` was 1.
- R9: `bw_code_o` encodes 0=14 Hz, 1=28 Hz, 2=56 Hz, 3=890 Hz. `bw_mode_i`=0 gives 0 and `bw_mode_i`=1 gives 1. `bw_mode_i`=2 or 3 is wideband, which depends on the kHz frequency of the selected reference: 3 at 64 or above, 2 from 8 up to 63, 0 below 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable; low holds the idle state |
| ref_ok_i | input | NUM_REF | Per-reference qualification flag, 1 = usable |
| prio_i | input | NUM_REF*PRIO_W | Packed priority values, reference i at bits [i*PRIO_W +: PRIO_W] |
| revert_i | input | 1 | Revertive automatic selection |
| manual_i | input | 1 | 1 = manual index, 0 = automatic |
| man_idx_i | input | IDX_W | Forced reference index in manual mode |
| hitless_en_i | input | 1 | Enables the switch request pulse |
| lock_i | input | 1 | Lock indication from the loop |
| bw_mode_i | input | 2 | 0 = 14 Hz, 1 = 28 Hz, 2/3 = wideband |
| freq_khz_i | input | NUM_REF*FREQ_W | Packed detected frequency per reference in kHz |
| sel_idx_o | output | IDX_W | Selected reference index |
| mode_o | output | 2 | 0 free-run, 1 locked, 2 holdover |
| bw_code_o | output | 2 | Loop bandwidth code |
| hitless_req_o | output | 1 | One-cycle phase absorption request |

## Verification
The assertions assume that every input is at a known 0 or 1 value at each rising edge from reset onward. They also assume that `lock_i` and `ref_ok_i` are treated as plain levels, so their history is not checked. The stimulus drives every input from time zero and changes inputs only on the falling edge. Random frequencies and priorities stay inside their port widths. Manual indices are always below eight, so every index the checker sees names a real reference.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    typedef enum logic [1:0] {
        MODE_FREE = 2'd0,
        MODE_LOCK = 2'd1,
        MODE_HOLD = 2'd2
    } mode_e;

    localparam logic [1:0] BW_14HZ  = 2'd0;
    localparam logic [1:0] BW_28HZ  = 2'd1;
    localparam logic [1:0] BW_56HZ  = 2'd2;
    localparam logic [1:0] BW_890HZ = 2'd3;

    localparam logic [1:0] BWM_NARROW = 2'd0;
    localparam logic [1:0] BWM_MEDIUM = 2'd1;
endpackage

// File: rtl/refsel_pick.sv
// Finds the most preferred qualified reference; ties go to the lower index.
module refsel_pick #(
    parameter  int NUM_REF = 8,
    parameter  int PRIO_W  = 3,
    localparam int IDX_W   = $clog2(NUM_REF)
) (
    input  logic [NUM_REF-1:0]        ref_ok_i,
    input  logic [NUM_REF*PRIO_W-1:0] prio_i,
    output logic [IDX_W-1:0]          best_idx_o,
    output logic                      any_ok_o
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_idx_o = '0;
        any_ok_o   = 1'b0;
        best_p     = '0;
        for (int i = 0; i < NUM_REF; i++) begin
            if (ref_ok_i[i] && (!any_ok_o || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
                any_ok_o   = 1'b1;
                best_p     = prio_i[i*PRIO_W +: PRIO_W];
                best_idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/refsel_bw.sv
// Maps the bandwidth mode and the active reference frequency to a code.
module refsel_bw
    import refsel_pkg::*;
#(
    parameter int FREQ_W     = 17,
    parameter int WB_HI_KHZ  = 64,
    parameter int WB_MID_KHZ = 8
) (
    input  logic [1:0]        bw_mode_i,
    input  logic [FREQ_W-1:0] freq_i,
    output logic [1:0]        code_o
);
    always_comb begin
        if (bw_mode_i == BWM_NARROW) begin
            code_o = BW_14HZ;
        end else if (bw_mode_i == BWM_MEDIUM) begin
            code_o = BW_28HZ;
        end else if (freq_i >= FREQ_W'(WB_HI_KHZ)) begin
            code_o = BW_890HZ;
        end else if (freq_i >= FREQ_W'(WB_MID_KHZ)) begin
            code_o = BW_56HZ;
        end else begin
            code_o = BW_14HZ;
        end
    end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter  int NUM_REF    = 8,
    parameter  int PRIO_W     = 3,
    parameter  int FREQ_W     = 17,
    parameter  int WB_HI_KHZ  = 64,
    parameter  int WB_MID_KHZ = 8,
    localparam int IDX_W      = $clog2(NUM_REF)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable_i,
    input  logic [NUM_REF-1:0]        ref_ok_i,
    input  logic [NUM_REF*PRIO_W-1:0] prio_i,
    input  logic                      revert_i,
    input  logic                      manual_i,
    input  logic [IDX_W-1:0]          man_idx_i,
    input  logic                      hitless_en_i,
    input  logic                      lock_i,
    input  logic [1:0]                bw_mode_i,
    input  logic [NUM_REF*FREQ_W-1:0] freq_khz_i,
    output logic [IDX_W-1:0]          sel_idx_o,
    output logic [1:0]                mode_o,
    output logic [1:0]                bw_code_o,
    output logic                      hitless_req_o
);
    typedef struct packed {
        logic [IDX_W-1:0] sel;
        mode_e            mode;
        logic             hist;
        logic [1:0]       bw;
        logic             hit;
    } state_t;

    localparam state_t IDLE_ST = '{sel: '0, mode: MODE_FREE, hist: 1'b0, bw: BW_14HZ, hit: 1'b0};

    state_t st_d, st_q;

    logic [PRIO_W-1:0] prio_a [NUM_REF];
    logic [FREQ_W-1:0] freq_a [NUM_REF];

    for (genvar g = 0; g < NUM_REF; g++) begin : g_unpack
        assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
        assign freq_a[g] = freq_khz_i[g*FREQ_W +: FREQ_W];
    end

    logic [IDX_W-1:0] best_idx;
    logic             any_ok;

    refsel_pick #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W)) u_pick (
        .ref_ok_i   (ref_ok_i),
        .prio_i     (prio_i),
        .best_idx_o (best_idx),
        .any_ok_o   (any_ok)
    );

    // Next selected index
    logic [IDX_W-1:0] nsel_d;
    logic             cur_ok;
    logic             better;

    always_comb begin
        cur_ok = ref_ok_i[st_q.sel];
        better = revert_i && any_ok && (prio_a[best_idx] < prio_a[st_q.sel]);
        if (manual_i) begin
            nsel_d = man_idx_i;
        end else if (cur_ok && !better) begin
            nsel_d = st_q.sel;
        end else if (any_ok) begin
            nsel_d = best_idx;
        end else begin
            nsel_d = st_q.sel;
        end
    end

    logic [1:0] bw_next;

    refsel_bw #(.FREQ_W(FREQ_W), .WB_HI_KHZ(WB_HI_KHZ), .WB_MID_KHZ(WB_MID_KHZ)) u_bw (
        .bw_mode_i (bw_mode_i),
        .freq_i    (freq_a[nsel_d]),
        .code_o    (bw_next)
    );

    always_comb begin
        st_d = st_q;
        if (!enable_i) begin
            st_d = IDLE_ST;
        end else begin
            st_d.sel = nsel_d;
            if (ref_ok_i[nsel_d] && lock_i) begin
                st_d.mode = MODE_LOCK;
            end else if (st_q.hist) begin
                st_d.mode = MODE_HOLD;
            end else begin
                st_d.mode = MODE_FREE;
            end
            st_d.hist = st_q.hist || (st_d.mode == MODE_LOCK);
            st_d.bw   = bw_next;
            st_d.hit  = hitless_en_i && (nsel_d != st_q.sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= IDLE_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx_o     = st_q.sel;
    assign mode_o        = st_q.mode;
    assign bw_code_o     = st_q.bw;
    assign hitless_req_o = st_q.hit;
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk #(
    parameter  int NUM_REF = 8,
    localparam int IDX_W   = $clog2(NUM_REF)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable_i,
    input logic [NUM_REF-1:0] ref_ok_i,
    input logic               manual_i,
    input logic [IDX_W-1:0]   man_idx_i,
    input logic               hitless_en_i,
    input logic               lock_i,
    input logic [1:0]         bw_mode_i,
    input logic [IDX_W-1:0]   sel_idx_o,
    input logic [1:0]         mode_o,
    input logic [1:0]         bw_code_o,
    input logic               hitless_req_o
);
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (mode_o == 2'd0 && sel_idx_o == '0 && bw_code_o == 2'd0 && !hitless_req_o));

    p_lock_needs_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1) |-> ($past(lock_i) && ((($past(ref_ok_i) >> sel_idx_o) & NUM_REF'(1)) != '0)));

    p_hold_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2) |-> ($past(mode_o) != 2'd0));

    p_manual_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && manual_i) |=> (sel_idx_o == $past(man_idx_i)));

    p_pulse_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hitless_req_o |-> ($past(hitless_en_i) && sel_idx_o != $past(sel_idx_o)));

    p_fixed_bw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && bw_mode_i == 2'd1) |=> (bw_code_o == 2'd1));

    p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);
endmodule

bind refsel_ctrl refsel_ctrl_chk #(.NUM_REF(NUM_REF)) u_chk (.*);

// File: tb/refsel_ctrl_test.sv
module refsel_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [7:0]  ref_ok_i = '0;
    logic [23:0] prio_i;
    logic        revert_i = 1'b0;
    logic        manual_i = 1'b0;
    logic [2:0]  man_idx_i = '0;
    logic        hitless_en_i = 1'b0;
    logic        lock_i = 1'b0;
    logic [1:0]  bw_mode_i = '0;
    logic [135:0] freq_khz_i;
    logic [2:0]  sel_idx_o;
    logic [1:0]  mode_o, bw_code_o;
    logic        hitless_req_o;

    logic [2:0]  pr [8];
    logic [16:0] fq [8];

    int checks = 0, fails = 0;
    logic [2:0] m_sel = '0;
    logic [1:0] m_mode = '0, m_bw = '0;
    logic       m_hist = 1'b0, m_hit = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            prio_i[i*3 +: 3]      = pr[i];
            freq_khz_i[i*17 +: 17] = fq[i];
        end
    end

    refsel_ctrl uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] bw_of(input logic [1:0] m, input logic [16:0] f);
        if (m == 2'd0) return 2'd0;
        if (m == 2'd1) return 2'd1;
        if (f >= 17'd64) return 2'd3;
        if (f >= 17'd8) return 2'd2;
        return 2'd0;
    endfunction

    // Expected next state from the requirements
    task automatic model_next();
        logic [2:0] best, ns;
        logic found;
        if (!enable_i) begin
            m_sel = 0; m_mode = 0; m_hist = 0; m_hit = 0; m_bw = 0;
            return;
        end
        found = 0; best = 0;
        for (int i = 0; i < 8; i++)
            if (ref_ok_i[i] && (!found || pr[i] < pr[best])) begin found = 1; best = 3'(i); end
        if (manual_i) ns = man_idx_i;
        else if (ref_ok_i[m_sel] && !(revert_i && found && pr[best] < pr[m_sel])) ns = m_sel;
        else if (found) ns = best;
        else ns = m_sel;
        m_hit = hitless_en_i && (ns != m_sel);
        m_sel = ns;
        if (ref_ok_i[ns] && lock_i) m_mode = 2'd1;
        else if (m_hist) m_mode = 2'd2;
        else m_mode = 2'd0;
        if (m_mode == 2'd1) m_hist = 1;
        m_bw = bw_of(bw_mode_i, fq[ns]);
    endtask

    task automatic step(input string tag);
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk(tag, sel_idx_o, m_sel);
        chk("R6 mode", mode_o, m_mode);
        chk("R9 bandwidth", bw_code_o, m_bw);
        chk("R8 hitless", hitless_req_o, m_hit);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin pr[i] = 3'd4; fq[i] = 17'd8; end
        enable_i = 1'b1; ref_ok_i = 8'hFF; lock_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sel", sel_idx_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 bw", bw_code_o, 0);
        chk("R1 hit", hitless_req_o, 0);
        rst_n = 1'b1;
        hitless_en_i = 1'b1;
        pr[2] = 3'd1; pr[5] = 3'd1;
        step("R4 stay on ref0");
        ref_ok_i = 8'hFE;
        step("R2 tie to lower index");
        pr[0] = 3'd0; ref_ok_i = 8'hFF; revert_i = 1'b1;
        step("R3 revert to ref0");
        revert_i = 1'b0; pr[0] = 3'd2; pr[3] = 3'd0;
        step("R4 non-revertive hold");
        ref_ok_i = 8'h00;
        step("R5 none qualified");
        manual_i = 1'b1; man_idx_i = 3'd6;
        step("R7 manual disqualified");
        ref_ok_i = 8'h40;
        step("R7 manual qualified");
        bw_mode_i = 2'd2; ref_ok_i = 8'hFF;
        fq[1] = 17'd64; fq[2] = 17'd63; fq[3] = 17'd2; fq[4] = 17'd77760;
        for (int k = 1; k <= 4; k++) begin
            man_idx_i = 3'(k);
            step("R9 wideband select");
        end
        enable_i = 1'b0;
        step("R1 disabled");
        enable_i = 1'b1; manual_i = 1'b0; ref_ok_i = 8'h00;
        step("R6 free-run without history");
        // random phase
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            enable_i     = ($urandom % 40) != 0;
            ref_ok_i     = 8'($urandom);
            revert_i     = 1'($urandom);
            manual_i     = ($urandom % 5) == 0;
            man_idx_i    = 3'($urandom);
            hitless_en_i = ($urandom % 4) != 0;
            lock_i       = ($urandom % 3) != 0;
            bw_mode_i    = 2'($urandom);
            if ($urandom % 8 == 0)
                for (int i = 0; i < 8; i++) pr[i] = 3'($urandom);
            for (int i = 0; i < 8; i++)
                case ($urandom % 6)
                    0: fq[i] = 17'd2;
                    1: fq[i] = 17'd8;
                    2: fq[i] = 17'd63;
                    3: fq[i] = 17'd64;
                    4: fq[i] = 17'd19440;
                    default: fq[i] = 17'($urandom % 77761);
                endcase
            step("R2 R3 R5 random selection");
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule